// File: doc/BRIEF.md
# Replicated-Table Lookup Dispatcher

This block sits between a line-rate stream of route lookup requests and a bank of identical next-hop table copies kept in slow memory. One request can arrive every request cycle, while one table access occupies a copy for many cycles. The dispatcher keeps the line rate by handing successive request slots to successive copies in a fixed rotation. With as many copies as the access time holds request cycles, a copy is always idle again by the time its turn comes back.

Each accepted request gets a sequence tag. The tag is remembered against the copy that serves it. Copies may hand back their answers at different points inside the access window, so answers can arrive out of order. A reorder buffer with one entry per copy puts them back in request order and emits one result per cycle. An answer that arrives for the oldest outstanding request goes straight to the output register without waiting in the buffer.

If the copy count and the access time are configured so that the copy whose turn it is has not finished yet, the dispatcher lowers ready and holds its rotation instead of losing the request. A cycle with no request still uses up its turn in the rotation, provided the copy in turn is idle.

Top module: `lookup_dispatch`

## Requirements
- R1: After synchronous reset, `mem_req` is all zero, `rsp_valid` is low and `req_ready` is high.
- R2: Accepted requests go to copies in strict rotation 0, 1, …, NUM_REPL-1, 0, … Acceptance happens in a cycle with `req_valid` and `req_ready` both high. In the next cycle exactly one bit of `mem_req` is high: bit k for copy k. `mem_key` carries the accepted key in that cycle.
- R3: A cycle without `req_valid` in which the copy in turn is idle moves the rotation on by one copy. The next accepted request therefore skips that copy.
- R4: A copy gets a new `mem_req` pulse no sooner than ACC_LAT cycles after its previous one.
- R5: While the copy in turn is still busy, `req_ready` is low and the rotation stays on that copy. A request held on `req_valid` is issued to that copy once it frees up.
- R6: `rsp_valid` pulses once for each accepted request, in acceptance order. A copy may raise its `mem_rvalid` bit any number of cycles from 1 to ACC_LAT-1 after its `mem_req` pulse. `rsp_valid` rises no later than the cycle after the last of these answers needed to complete the order has arrived.
- R7: At most NUM_REPL requests are outstanding, counted from acceptance until release to the output register. With NUM_REPL outstanding and no release in that cycle, `req_ready` is low.
- R8: When NUM_REPL equals ACC_LAT, `req_ready` never falls, so a request can be accepted in every cycle.
- R9: `rsp_data` equals the word that copy k presented on `mem_rdata[k*RES_W +: RES_W]` in the cycle its `mem_rvalid[k]` was high for that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Request-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup request is presented |
| req_key | input | KEY_W | Lookup key of the request |
| req_ready | output | 1 | Request is taken in this cycle when valid |
| mem_req | output | NUM_REPL | One-hot start pulse, one bit per table copy |
| mem_key | output | KEY_W | Key for the copy selected by `mem_req` |
| mem_rvalid | input | NUM_REPL | Answer strobe, one bit per copy |
| mem_rdata | input | NUM_REPL*RES_W | Answer words, copy k in slice k |
| rsp_valid | output | 1 | In-order result is valid |
| rsp_data | output | RES_W | In-order result word |

## Verification
The bench runs two configurations side by side: a balanced one with fifteen copies and a fifteen-cycle access, and a short one with four copies and a six-cycle access in which the copy in turn is regularly still busy. In both, copies answer at staggered points of their window, so later requests often finish first. A design without reordering would emit results out of order. A design that dropped bypass timing would lower ready in the balanced case. Gaps in the request stream test rotation skipping: a design that froze the rotation on idle cycles would send requests to the wrong copy. A design that ignored busy copies would re-issue a copy early, or drop or misroute the held request.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    localparam int DEF_REPLICAS = 15;
    localparam int DEF_LATENCY  = 15;
    localparam int DEF_KEY_W    = 32;
    localparam int DEF_RES_W    = 16;

    // What the current request slot does with the copy in turn.
    typedef enum logic [1:0] {
        SLOT_ISSUE = 2'd0,
        SLOT_SKIP  = 2'd1,
        SLOT_HOLD  = 2'd2
    } slot_act_e;

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/lkd_rotor.sv
module lkd_rotor
    import lkd_pkg::*;
#(
    parameter int NR    = DEF_REPLICAS,
    parameter int LAT   = DEF_LATENCY,
    parameter int KEY_W = DEF_KEY_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [KEY_W-1:0]          req_key,
    input  logic                      room,
    output logic                      ready,
    output logic                      accept,
    output logic [idx_width(NR)-1:0]  issue_idx,
    output logic [NR-1:0]             mem_req,
    output logic [KEY_W-1:0]          mem_key
);
    localparam int IDX_W = idx_width(NR);
    localparam int CNT_W = idx_width(LAT);

    logic [IDX_W-1:0] turn;
    logic [CNT_W-1:0] hold_cnt [NR];
    logic [NR-1:0]    busy_vec;
    logic             busy_here;
    slot_act_e        act;

    // One countdown per copy: loaded on issue, copy free again at zero.
    for (genvar g = 0; g < NR; g++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_cnt[g] <= '0;
            end else if (accept && (turn == IDX_W'(g))) begin
                hold_cnt[g] <= CNT_W'(LAT - 1);
            end else if (hold_cnt[g] != '0) begin
                hold_cnt[g] <= hold_cnt[g] - 1'b1;
            end
        end
        assign busy_vec[g] = (hold_cnt[g] != '0);
    end

    assign busy_here = busy_vec[turn];

    always_comb begin
        if (busy_here) begin
            act = SLOT_HOLD;
        end else if (!req_valid) begin
            act = SLOT_SKIP;
        end else if (room) begin
            act = SLOT_ISSUE;
        end else begin
            act = SLOT_HOLD;
        end
    end

    assign ready     = !busy_here && room;
    assign accept    = (act == SLOT_ISSUE);
    assign issue_idx = turn;

    always_ff @(posedge clk) begin
        if (rst) begin
            turn    <= '0;
            mem_req <= '0;
            mem_key <= '0;
        end else begin
            if (act != SLOT_HOLD) begin
                turn <= IDX_W'(wrap_inc(int'(turn), NR));
            end
            mem_req <= accept ? (NR'(1) << turn) : '0;
            if (accept) begin
                mem_key <= req_key;
            end
        end
    end

endmodule

// File: rtl/lkd_rob.sv
module lkd_rob
    import lkd_pkg::*;
#(
    parameter int NR    = DEF_REPLICAS,
    parameter int RES_W = DEF_RES_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      accept,
    input  logic [idx_width(NR)-1:0]  issue_idx,
    input  logic [NR-1:0]             mem_rvalid,
    input  logic [NR*RES_W-1:0]       mem_rdata,
    output logic                      room,
    output logic                      rsp_valid,
    output logic [RES_W-1:0]          rsp_data
);
    localparam int IDX_W = idx_width(NR);
    localparam int OUT_W = $clog2(NR + 1);

    typedef struct packed {
        logic             full;
        logic [RES_W-1:0] data;
    } rob_ent_t;

    rob_ent_t         slot   [NR];
    logic [IDX_W-1:0] tag_of [NR];
    logic [IDX_W-1:0] next_tag;
    logic [IDX_W-1:0] head;
    logic [OUT_W-1:0] outst;

    logic [NR-1:0]    byp_sel;
    logic             byp_hit;
    logic [RES_W-1:0] byp_data;
    logic             from_rob;
    logic             release_now;
    logic [RES_W-1:0] rel_data;

    // Answer for the oldest request this cycle goes straight out.
    always_comb begin
        byp_data = '0;
        for (int k = 0; k < NR; k++) begin
            byp_sel[k] = mem_rvalid[k] && (tag_of[k] == head);
            if (byp_sel[k]) begin
                byp_data = mem_rdata[k*RES_W +: RES_W];
            end
        end
        byp_hit     = |byp_sel;
        from_rob    = slot[head].full;
        release_now = from_rob || byp_hit;
        rel_data    = from_rob ? slot[head].data : byp_data;
    end

    assign room = (outst < OUT_W'(NR)) || release_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NR; k++) begin
                slot[k]   <= '0;
                tag_of[k] <= '0;
            end
            next_tag  <= '0;
            head      <= '0;
            outst     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (accept) begin
                tag_of[issue_idx] <= next_tag;
                next_tag          <= IDX_W'(wrap_inc(int'(next_tag), NR));
            end
            for (int k = 0; k < NR; k++) begin
                if (mem_rvalid[k] && !byp_sel[k]) begin
                    slot[tag_of[k]].full <= 1'b1;
                    slot[tag_of[k]].data <= mem_rdata[k*RES_W +: RES_W];
                end
            end
            if (from_rob) begin
                slot[head].full <= 1'b0;
            end
            if (release_now) begin
                head     <= IDX_W'(wrap_inc(int'(head), NR));
                rsp_data <= rel_data;
            end
            rsp_valid <= release_now;
            case ({accept, release_now})
                2'b10:   outst <= outst + 1'b1;
                2'b01:   outst <= outst - 1'b1;
                default: outst <= outst;
            endcase
        end
    end

endmodule

// File: rtl/lookup_dispatch.sv
module lookup_dispatch
    import lkd_pkg::*;
#(
    parameter int NUM_REPL = DEF_REPLICAS,
    parameter int ACC_LAT  = DEF_LATENCY,
    parameter int KEY_W    = DEF_KEY_W,
    parameter int RES_W    = DEF_RES_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [KEY_W-1:0]          req_key,
    output logic                      req_ready,
    output logic [NUM_REPL-1:0]       mem_req,
    output logic [KEY_W-1:0]          mem_key,
    input  logic [NUM_REPL-1:0]       mem_rvalid,
    input  logic [NUM_REPL*RES_W-1:0] mem_rdata,
    output logic                      rsp_valid,
    output logic [RES_W-1:0]          rsp_data
);
    localparam int IDX_W = idx_width(NUM_REPL);

    logic             room;
    logic             accept;
    logic [IDX_W-1:0] issue_idx;

    lkd_rotor #(
        .NR    (NUM_REPL),
        .LAT   (ACC_LAT),
        .KEY_W (KEY_W)
    ) u_rotor (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_key   (req_key),
        .room      (room),
        .ready     (req_ready),
        .accept    (accept),
        .issue_idx (issue_idx),
        .mem_req   (mem_req),
        .mem_key   (mem_key)
    );

    lkd_rob #(
        .NR    (NUM_REPL),
        .RES_W (RES_W)
    ) u_rob (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .issue_idx  (issue_idx),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .room       (room),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

endmodule

// File: rtl/lkd_checker.sv
module lkd_checker #(
    parameter int NR  = 15,
    parameter int LAT = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [NR-1:0] mem_req,
    input logic          rsp_valid
);
    localparam int GW = $clog2(LAT + 1);
    localparam int CW = $clog2(NR + 3);

    logic [CW-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            case ({req_valid && req_ready, rsp_valid})
                2'b10:   pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_req == '0) && !rsp_valid); // R1

    AST_ONE_COPY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_req)); // R2

    AST_ISSUE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> $onehot(mem_req)); // R2

    AST_NO_SPURIOUS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> (mem_req == '0)); // R2

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (pend != '0)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        pend <= CW'(NR + 1)); // R7

    for (genvar g = 0; g < NR; g++) begin : g_gap
        logic [GW-1:0] gap;
        always_ff @(posedge clk) begin
            if (rst) begin
                gap <= GW'(LAT);
            end else if (mem_req[g]) begin
                gap <= GW'(1);
            end else if (gap < GW'(LAT)) begin
                gap <= gap + 1'b1;
            end
        end
        AST_COPY_REST: assert property (@(posedge clk) disable iff (rst)
            mem_req[g] |-> (gap >= GW'(LAT))); // R4
    end

endmodule

bind lookup_dispatch lkd_checker #(
    .NR  (NUM_REPL),
    .LAT (ACC_LAT)
) u_lkd_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .rsp_valid (rsp_valid)
);

// File: tb/test_lookup_dispatch.sv
`timescale 1ns/1ps

module lkd_env #(
    parameter int NR  = 15,
    parameter int LAT = 15
) (
    input  logic clk,
    output int   n_cmp,
    output int   n_bad,
    output logic done
);
    localparam int KW = 32;
    localparam int RW = 16;
    localparam int RUN_CYC = 260;

    logic                rst;
    logic                req_valid;
    logic [KW-1:0]       req_key;
    logic                req_ready;
    logic [NR-1:0]       mem_req;
    logic [KW-1:0]       mem_key;
    logic [NR-1:0]       mem_rvalid;
    logic [NR*RW-1:0]    mem_rdata;
    logic                rsp_valid;
    logic [RW-1:0]       rsp_data;

    lookup_dispatch #(
        .NUM_REPL (NR),
        .ACC_LAT  (LAT),
        .KEY_W    (KW),
        .RES_W    (RW)
    ) i_lookup_dispatch (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_key    (req_key),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .mem_key    (mem_key),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    function automatic logic [RW-1:0] answer(input logic [KW-1:0] k);
        return k[15:0] ^ k[31:16] ^ 16'hA5C3;
    endfunction

    function automatic bit want_req(input int c);
        if (c < 60)  return 1'b1;
        if (c < 100) return (c % 2) == 0;
        if (c < 130) return 1'b0;
        if (c < 200) return ((c * 7) % 5) != 0;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (cfg %0d/%0d): actual %0h expected %0h", req, NR, LAT, act, exp);
        end
    endtask

    initial begin
        int            last_dec [NR];
        int            ret_at   [NR];
        logic [KW-1:0] ret_key  [NR];
        logic [RW-1:0] exp_q [$];
        logic [NR-1:0] exp_req;
        logic [KW-1:0] exp_key;
        int            turn;
        int            acc_cnt;
        int            rsp_cnt;
        int            stalls;
        int            kcnt;
        bit            holding;

        n_cmp = 0; n_bad = 0; done = 1'b0;
        rst = 1'b1; req_valid = 1'b0; req_key = '0;
        mem_rvalid = '0; mem_rdata = '0;
        for (int k = 0; k < NR; k++) begin
            last_dec[k] = -1000; ret_at[k] = -1; ret_key[k] = '0;
        end
        exp_req = '0; exp_key = '0; turn = 0;
        acc_cnt = 0; rsp_cnt = 0; stalls = 0; kcnt = 0; holding = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int c = 0; c < RUN_CYC; c++) begin
            if (c != 0) @(negedge clk);
            // copies answer at staggered points of their window
            for (int k = 0; k < NR; k++) begin
                mem_rvalid[k] = (ret_at[k] == c);
                mem_rdata[k*RW +: RW] = (ret_at[k] == c) ? answer(ret_key[k]) : RW'(16'h0BAD);
            end
            req_valid = holding || want_req(c);
            req_key   = (kcnt + 1) * 32'h9E3779B1;
            #1;

            if (c == 0) begin
                check(mem_req == '0, "R1 mem_req", mem_req, 0);
                check(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
                check(req_ready, "R1 req_ready", req_ready, 1);
            end

            // R2 R3: copy chosen for the previous acceptance
            check(mem_req == exp_req, "R2 R3 copy select", mem_req, exp_req);
            if (exp_req != '0) begin
                check(mem_key == exp_key, "R2 mem_key", mem_key, exp_key);
            end
            for (int k = 0; k < NR; k++) begin
                if (mem_req[k]) begin
                    ret_at[k]  = c + (LAT - 1 - (k % 3));
                    ret_key[k] = mem_key;
                end
            end

            // R6 R9: in-order results with the right data
            if (rsp_valid) begin
                rsp_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected result", rsp_data, 0);
                end else begin
                    logic [RW-1:0] e;
                    e = exp_q.pop_front();
                    check(rsp_data == e, "R6 R9 result order/data", rsp_data, e);
                end
            end

            // R5 R7 R8: ready against copy state and occupancy
            begin
                bit free_here;
                int outst;
                free_here = (c - last_dec[turn]) >= LAT;
                outst     = acc_cnt - rsp_cnt;
                check(outst <= NR, "R7 outstanding bound", outst, NR);
                if (req_ready) begin
                    check(free_here, "R5 ready while copy busy", req_ready, 0);
                end else begin
                    check(!free_here || outst == NR, "R5 R7 ready low without cause", req_ready, 1);
                end
                if (NR == LAT && req_valid) begin
                    check(req_ready, "R8 full rate ready", req_ready, 1);
                end

                exp_req = '0;
                if (req_valid && req_ready) begin
                    exp_req = NR'(1) << turn;
                    exp_key = req_key;
                    exp_q.push_back(answer(req_key));
                    last_dec[turn] = c;
                    turn = (turn + 1) % NR;
                    acc_cnt++;
                    kcnt++;
                    holding = 1'b0;
                end else if (req_valid) begin
                    stalls++;
                    holding = 1'b1;
                end else if (free_here) begin
                    turn = (turn + 1) % NR;
                end
            end
        end

        check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        check(rsp_cnt == acc_cnt, "R6 result count", rsp_cnt, acc_cnt);
        if (NR < LAT) begin
            check(stalls > 0, "R5 stall seen on short config", stalls, 1);
        end
        done = 1'b1;
    end

endmodule

module test_lookup_dispatch;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int   cmp_a, bad_a, cmp_b, bad_b;
    logic done_a, done_b;

    lkd_env #(.NR(15), .LAT(15)) u_balanced (
        .clk (clk), .n_cmp (cmp_a), .n_bad (bad_a), .done (done_a)
    );

    lkd_env #(.NR(4), .LAT(6)) u_short (
        .clk (clk), .n_cmp (cmp_b), .n_bad (bad_b), .done (done_b)
    );

    initial begin
        int  cyc;
        int  extra;
        cyc = 0;
        extra = 0;
        while (!(done_a === 1'b1 && done_b === 1'b1) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 20000) begin
            extra = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 cmp_a + cmp_b + extra, bad_a + bad_b + extra);
        $finish;
    end

endmodule